// File: doc/BRIEF.md
# DMA interrupt status classifier

This block gathers completion and error events from a bank of DMA channels into two status words and raises one interrupt line from them. Each error event carries a type flag that marks it as a bus error or a termination error. A termination error that coincides with a completion on the same channel is treated as a normal completion, not as a failure.

From the live status the block forms one vector with the reportable errors in the upper half and the completions in the lower half. It presents the highest set bit as the event to service next, so any error comes before any completion, and a higher channel comes before a lower one. The servicing agent acknowledges the presented event. That clears exactly the bit that was serviced. For an error it also issues a one-cycle reset request for that channel; the block itself does not act on that request. Software can read both status words, program the per-channel interrupt enables, and clear bits by writing ones to clear aliases.

`NUM_CH` must be a power of two. The event index then splits into an error flag (top bit) and a channel number (low bits).

Top module: `dma_irq_classifier`

## Requirements
- R1: A pulse on `comp_pulse[i]` sets completion bit i, which reads back in bit i of the status word (`reg_addr` 0). A pulse and a clear of the same bit in the same cycle leave the bit set.
- R2: A pulse on `err_pulse[i]` sets error flag i, which reads back in bit i of the error word (`reg_addr` 2). When `err_bus[i]` is high in the same cycle, the type bit in bit NUM_CH+i is also set; 1 means bus error and 0 means termination error.
- R3: A write to `reg_addr` 0 loads the interrupt enables from bits [2*NUM_CH-1:NUM_CH] and does not change the completion bits. A write to `reg_addr` 2 changes nothing.
- R4: A write to `reg_addr` 1 clears every status-word bit, enable or completion, whose write-data bit is one. A write to `reg_addr` 3 does the same for the error flags and type bits, each half independently.
- R5: `irq` is high exactly while some completion bit has its enable set, or while any error flag is set. The enables do not gate error flags.
- R6: An error on channel i is reportable when its flag is set and either its type bit is set, or its type bit is clear and completion bit i is clear.
- R7: The presented event is the highest set bit of {reportable errors, completions}. `evt_err` marks the upper half and `evt_chan` gives the channel.
- R8: The event outputs reflect the status held one cycle earlier. In the cycle after an accepted acknowledge, `evt_valid` is low.
- R9: An accepted acknowledge clears only the serviced bit. An error acknowledge clears that channel's flag and type bit. A completion acknowledge clears the completion bit and also drops that channel's suppressed termination flag, if one is present.
- R10: In the cycle after an error event is acknowledged, `chan_rst_req` is high for exactly that channel, for one cycle.
- R11: While reset is applied, all status bits, enables, `irq`, `evt_valid` and `chan_rst_req` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| comp_pulse | input | NUM_CH | Per-channel completion event |
| err_pulse | input | NUM_CH | Per-channel error event |
| err_bus | input | NUM_CH | Error type with `err_pulse`: 1 bus, 0 termination |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 status, 1 status clear, 2 error, 3 error clear |
| reg_wdata | input | 2*NUM_CH | Write data |
| reg_rdata | output | 2*NUM_CH | Read data of the selected word (addresses 1 and 3 read as 0 and 2) |
| evt_valid | output | 1 | An event is presented |
| evt_chan | output | log2(NUM_CH) | Channel of the presented event |
| evt_err | output | 1 | Presented event is an error |
| evt_ack | input | 1 | Acknowledge of the presented event (taken only when `evt_valid`) |
| irq | output | 1 | Interrupt request |
| chan_rst_req | output | NUM_CH | One-cycle per-channel reset request |

## Verification
The bench builds the block with `NUM_CH` = 4, so the combined vector has only 8 bits. This makes it feasible to sweep every completion mask against every error mask, with four bus-type patterns and four enable patterns. All coincidences of termination errors with completions are therefore covered, as are all priority orderings between the two halves and across channels. Each injected pattern is drained acknowledge by acknowledge against an arithmetic model. Directed steps cover set-versus-clear collisions, the ignored write address and the event latency.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  // register select codes; the clear aliases sit one above their word
  typedef enum logic [1:0] {
    SEL_STAT     = 2'd0,
    SEL_STAT_CLR = 2'd1,
    SEL_ERR      = 2'd2,
    SEL_ERR_CLR  = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/irqc_status_bank.sv
module irqc_status_bank
  import irqc_pkg::*;
#(
  parameter int NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] comp_pulse,
  input  logic [NUM_CH-1:0] err_pulse,
  input  logic [NUM_CH-1:0] err_bus,
  input  logic              wr_en,
  input  reg_sel_e          wr_sel,
  input  logic [2*NUM_CH-1:0] wr_data,
  input  logic              ack_en,
  input  logic              ack_err,
  input  logic [NUM_CH-1:0] ack_mask,
  output logic [NUM_CH-1:0] comp_q,
  output logic [NUM_CH-1:0] en_q,
  output logic [NUM_CH-1:0] flag_q,
  output logic [NUM_CH-1:0] type_q
);

  localparam int DW = 2 * NUM_CH;

  logic [NUM_CH-1:0] comp_d, en_d, flag_d, type_d;
  logic [NUM_CH-1:0] clr_comp, clr_flag, clr_type;
  logic              upd;

  always_comb begin
    clr_comp = '0;
    clr_flag = '0;
    clr_type = '0;
    en_d     = en_q;
    if (wr_en) begin
      case (wr_sel)
        SEL_STAT:     en_d = wr_data[DW-1:NUM_CH];
        SEL_STAT_CLR: begin
          clr_comp = wr_data[NUM_CH-1:0];
          en_d     = en_q & ~wr_data[DW-1:NUM_CH];
        end
        SEL_ERR_CLR:  begin
          clr_flag = wr_data[NUM_CH-1:0];
          clr_type = wr_data[DW-1:NUM_CH];
        end
        default: ;
      endcase
    end
    if (ack_en) begin
      if (ack_err) begin
        clr_flag = clr_flag | ack_mask;
        clr_type = clr_type | ack_mask;
      end else begin
        // a termination flag hidden behind this completion goes with it
        clr_comp = clr_comp | ack_mask;
        clr_flag = clr_flag | (ack_mask & ~type_q);
      end
    end
    // new events win over clears of the same cycle
    comp_d = (comp_q & ~clr_comp) | comp_pulse;
    flag_d = (flag_q & ~clr_flag) | err_pulse;
    type_d = (type_q & ~clr_type) | (err_pulse & err_bus);
    upd    = wr_en | ack_en | (|comp_pulse) | (|err_pulse);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      comp_q <= '0;
      en_q   <= '0;
      flag_q <= '0;
      type_q <= '0;
    end else if (upd) begin
      comp_q <= comp_d;
      en_q   <= en_d;
      flag_q <= flag_d;
      type_q <= type_d;
    end
  end

endmodule

// File: rtl/irqc_classify.sv
module irqc_classify #(
  parameter int NUM_CH = 16
) (
  input  logic [NUM_CH-1:0]   comp,
  input  logic [NUM_CH-1:0]   flag,
  input  logic [NUM_CH-1:0]   bus,
  output logic [2*NUM_CH-1:0] vec
);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    // bus errors always count; termination errors only without completion
    assign vec[NUM_CH+g] = flag[g] & (bus[g] | ~comp[g]);
    assign vec[g]        = comp[g];
  end

endmodule

// File: rtl/irqc_prio_enc.sv
module irqc_prio_enc #(
  parameter int W  = 32,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    // ascending scan, so the last hit is the highest set bit
    for (int i = 0; i < W; i++) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end

endmodule

// File: rtl/dma_irq_classifier.sv
module dma_irq_classifier
  import irqc_pkg::*;
#(
  parameter int NUM_CH = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_CH-1:0]         comp_pulse,
  input  logic [NUM_CH-1:0]         err_pulse,
  input  logic [NUM_CH-1:0]         err_bus,
  input  logic                      reg_wr,
  input  logic [1:0]                reg_addr,
  input  logic [2*NUM_CH-1:0]       reg_wdata,
  output logic [2*NUM_CH-1:0]       reg_rdata,
  output logic                      evt_valid,
  output logic [$clog2(NUM_CH)-1:0] evt_chan,
  output logic                      evt_err,
  input  logic                      evt_ack,
  output logic                      irq,
  output logic [NUM_CH-1:0]         chan_rst_req
);

  localparam int DW = 2 * NUM_CH;
  localparam int CW = $clog2(NUM_CH);
  localparam int IW = CW + 1;

  logic              rst_meta, rst_sync_n;
  logic [NUM_CH-1:0] comp_q, en_q, flag_q, type_q;
  logic [DW-1:0]     vec;
  logic              found;
  logic [IW-1:0]     idx;
  logic              ack_take;
  logic [NUM_CH-1:0] ack_mask;
  logic              evt_v_q, evt_v_d;
  logic              evt_e_q, evt_e_d;
  logic [CW-1:0]     evt_c_q, evt_c_d;
  logic [NUM_CH-1:0] rst_q, rst_d;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  assign ack_take = evt_ack & evt_v_q;
  assign ack_mask = NUM_CH'(1) << evt_c_q;

  irqc_status_bank #(.NUM_CH(NUM_CH)) u_bank (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .comp_pulse (comp_pulse),
    .err_pulse  (err_pulse),
    .err_bus    (err_bus),
    .wr_en      (reg_wr),
    .wr_sel     (reg_sel_e'(reg_addr)),
    .wr_data    (reg_wdata),
    .ack_en     (ack_take),
    .ack_err    (evt_e_q),
    .ack_mask   (ack_mask),
    .comp_q     (comp_q),
    .en_q       (en_q),
    .flag_q     (flag_q),
    .type_q     (type_q)
  );

  irqc_classify #(.NUM_CH(NUM_CH)) u_cls (
    .comp (comp_q),
    .flag (flag_q),
    .bus  (type_q),
    .vec  (vec)
  );

  irqc_prio_enc #(.W(DW), .IW(IW)) u_enc (
    .vec   (vec),
    .found (found),
    .idx   (idx)
  );

  always_comb begin
    // an accepted acknowledge blanks the event for one cycle so the
    // serviced bit cannot be presented twice
    evt_v_d = ack_take ? 1'b0 : found;
    evt_e_d = idx[IW-1];
    evt_c_d = idx[CW-1:0];
    rst_d   = (ack_take && evt_e_q) ? ack_mask : '0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      evt_v_q <= 1'b0;
      evt_e_q <= 1'b0;
      evt_c_q <= '0;
      rst_q   <= '0;
    end else begin
      evt_v_q <= evt_v_d;
      evt_e_q <= evt_e_d;
      evt_c_q <= evt_c_d;
      rst_q   <= rst_d;
    end
  end

  assign evt_valid    = evt_v_q;
  assign evt_err      = evt_e_q;
  assign evt_chan     = evt_c_q;
  assign chan_rst_req = rst_q;
  assign irq          = (|(comp_q & en_q)) | (|flag_q);
  assign reg_rdata    = reg_addr[1] ? {type_q, flag_q} : {en_q, comp_q};

endmodule

// File: rtl/dma_irq_classifier_chk.sv
module dma_irq_classifier_chk #(
  parameter int NUM_CH = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] comp_pulse,
  input logic [NUM_CH-1:0] err_pulse,
  input logic              reg_wr,
  input logic [NUM_CH-1:0] comp_q,
  input logic [NUM_CH-1:0] flag_q,
  input logic [NUM_CH-1:0] type_q,
  input logic              evt_valid,
  input logic              evt_err,
  input logic              evt_ack,
  input logic              irq,
  input logic [NUM_CH-1:0] chan_rst_req
);

  p_set_wins_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (|comp_pulse) |=> ((comp_q & $past(comp_pulse)) == $past(comp_pulse)));

  p_err_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_pulse) |=> ((flag_q & $past(err_pulse)) == $past(err_pulse)));

  p_irq_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past((|comp_pulse) || (|err_pulse) || reg_wr));

  p_err_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !evt_err) |-> $past((flag_q & (type_q | ~comp_q)) == '0));

  p_ack_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_ack && evt_valid) |=> !evt_valid);

  p_rst_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chan_rst_req));

  p_rst_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|chan_rst_req) |-> $past(evt_ack && evt_valid && evt_err));

endmodule

bind dma_irq_classifier dma_irq_classifier_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .comp_pulse   (comp_pulse),
  .err_pulse    (err_pulse),
  .reg_wr       (reg_wr),
  .comp_q       (comp_q),
  .flag_q       (flag_q),
  .type_q       (type_q),
  .evt_valid    (evt_valid),
  .evt_err      (evt_err),
  .evt_ack      (evt_ack),
  .irq          (irq),
  .chan_rst_req (chan_rst_req)
);

// File: tb/dma_irq_classifier_test.sv
module dma_irq_classifier_test;

  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int DW = 2 * N;
  localparam int CW = 2;

  logic          clk;
  logic          rst_n;
  logic [N-1:0]  comp_pulse, err_pulse, err_bus;
  logic          reg_wr;
  logic [1:0]    reg_addr;
  logic [DW-1:0] reg_wdata, reg_rdata;
  logic          evt_valid, evt_err, evt_ack, irq;
  logic [CW-1:0] evt_chan;
  logic [N-1:0]  chan_rst_req;

  int n_chk;
  int n_fail;
  bit done;

  dma_irq_classifier #(.NUM_CH(N)) uut (
    .clk(clk), .rst_n(rst_n), .comp_pulse(comp_pulse), .err_pulse(err_pulse),
    .err_bus(err_bus), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .evt_valid(evt_valid), .evt_chan(evt_chan),
    .evt_err(evt_err), .evt_ack(evt_ack), .irq(irq), .chan_rst_req(chan_rst_req)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulse(input logic [N-1:0] c, input logic [N-1:0] f, input logic [N-1:0] b);
    comp_pulse = c; err_pulse = f; err_bus = b;
    tick();
    comp_pulse = '0; err_pulse = '0; err_bus = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v;
    logic [N-1:0] en, mc, mf, mt, rep;
    logic [DW-1:0] vec;
    int hi;
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; comp_pulse = '0; err_pulse = '0; err_bus = '0;
    reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; evt_ack = 1'b0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", "irq", irq, 0);
    chk("R11", "evt_valid", evt_valid, 0);
    chk("R11", "chan_rst_req", chan_rst_req, 0);
    rd(2'd0, v); chk("R11", "status word", v, 0);
    rd(2'd2, v); chk("R11", "error word", v, 0);
    rst_n = 1'b1;
    repeat (4) tick();

    // R3: enables load, completion half ignored, error word write ignored
    wr(2'd0, 8'hA5);
    rd(2'd0, v); chk("R3", "enable load", v, 8'hA0);
    wr(2'd2, 8'hFF);
    rd(2'd2, v); chk("R3", "error word write ignored", v, 8'h00);
    chk("R3", "irq after ignored write", irq, 0);

    // R5: completion on a disabled channel does not raise irq
    pulse(4'b0001, 4'b0000, 4'b0000);
    rd(2'd0, v); chk("R1", "completion set", v, 8'hA1);
    chk("R5", "disabled completion irq", irq, 0);
    wr(2'd1, 8'h01);
    rd(2'd0, v); chk("R4", "completion clear", v, 8'hA0);
    pulse(4'b0010, 4'b0000, 4'b0000);
    chk("R5", "enabled completion irq", irq, 1);
    wr(2'd1, 8'h02);
    chk("R5", "irq drops", irq, 0);

    // R1: pulse and clear of the same bit together leave it set
    comp_pulse = 4'b0100;
    wr(2'd1, 8'h04);
    comp_pulse = '0;
    rd(2'd0, v); chk("R1", "set wins over clear", v, 8'hA4);
    wr(2'd1, 8'h04);
    wr(2'd1, 8'hF0);
    rd(2'd0, v); chk("R4", "enable clear", v, 8'h00);
    tick();

    // R4: error word halves clear independently; R5 error irq ungated
    pulse(4'b0000, 4'b1000, 4'b1000);
    rd(2'd2, v); chk("R2", "bus error latch", v, 8'h88);
    chk("R5", "error irq without enable", irq, 1);
    wr(2'd3, 8'h08);
    rd(2'd2, v); chk("R4", "flag clear keeps type", v, 8'h80);
    chk("R5", "irq after flag clear", irq, 0);
    wr(2'd3, 8'h80);
    rd(2'd2, v); chk("R4", "type clear", v, 8'h00);
    tick();
    chk("R8", "idle after clears", evt_valid, 0);

    // R8: latency of the event outputs
    pulse(4'b0100, 4'b0000, 4'b0000);
    chk("R8", "not yet presented", evt_valid, 0);
    tick();
    chk("R8", "presented next cycle", evt_valid, 1);
    chk("R7", "channel", evt_chan, 2);
    chk("R7", "kind", evt_err, 0);
    evt_ack = 1'b1; tick(); evt_ack = 1'b0;
    chk("R8", "blank after ack", evt_valid, 0);
    chk("R10", "no reset on completion", chan_rst_req, 0);
    tick();
    chk("R9", "drained", evt_valid, 0);

    // sweep: enables x completions x errors x bus-type patterns
    for (int p = 0; p < 4; p++) begin
      en = (p == 0) ? 4'h0 : (p == 1) ? 4'hF : (p == 2) ? 4'h5 : 4'hA;
      wr(2'd0, {en, 4'h0});
      for (int c = 0; c < 16; c++) begin
        for (int f = 0; f < 16; f++) begin
          for (int tp = 0; tp < 4; tp++) begin
            logic [N-1:0] tpat;
            tpat = (tp == 0) ? 4'h0 : (tp == 1) ? 4'hF : (tp == 2) ? 4'h6 : 4'h9;
            mc = N'(c); mf = N'(f); mt = tpat & N'(f);
            pulse(mc, mf, tpat);
            rd(2'd0, v); chk("R1", "sweep status word", v, {en, mc});
            rd(2'd2, v); chk("R2", "sweep error word", v, {mt, mf});
            chk("R5", "sweep irq", irq, ((|(mc & en)) || (|mf)) ? 1 : 0);
            tick();
            for (int k = 0; k < 2 * N + 1; k++) begin
              rep = mf & (mt | ~mc);
              vec = {rep, mc};
              if (vec == '0) begin
                chk("R6", "nothing reportable", evt_valid, 0);
                break;
              end
              hi = 0;
              for (int b = 0; b < DW; b++) if (vec[b]) hi = b;
              chk("R7", "valid", evt_valid, 1);
              chk("R7", "channel order", evt_chan, hi % N);
              chk("R6", "error classification", evt_err, (hi >= N) ? 1 : 0);
              chk("R5", "irq while draining", irq, ((|(mc & en)) || (|mf)) ? 1 : 0);
              evt_ack = 1'b1; tick(); evt_ack = 1'b0;
              chk("R8", "blank after ack", evt_valid, 0);
              chk("R10", "reset request",
                  chan_rst_req, (hi >= N) ? (32'd1 << (hi - N)) : 0);
              if (hi >= N) begin
                mf[hi - N] = 1'b0;
                mt[hi - N] = 1'b0;
              end else begin
                mc[hi] = 1'b0;
                if (!mt[hi]) mf[hi] = 1'b0;
              end
              tick();
              chk("R10", "reset request one cycle", chan_rst_req, 0);
            end
            rd(2'd0, v); chk("R9", "status after drain", v, {en, 4'h0});
            rd(2'd2, v); chk("R9", "error after drain", v, 0);
          end
        end
      end
    end

    done = 1'b1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule